// File: doc/BRIEF.md
# SMBus Block Transfer Buffer

This block is the buffered path of an SMBus host for block writes and block reads. Software loads up to 32 data bytes into a small memory through one data register, sets the byte count, and starts a transfer. The block then sends the whole block, or collects it, on the bus in a single transaction, without software touching each byte.

The block data register has no address of its own inside the buffer. An internal index points at one entry. Every read or write of the data register uses that entry and then moves the index forward. The index wraps from the last entry back to entry 0. Any read of the control register moves the index back to 0, so software reads the control register before it loads or unloads the buffer.

On the bus side the block drives a byte-level engine. It asks for one operation at a time: a byte sent after a start condition, a plain byte sent, a byte received with acknowledge, a byte received with not-acknowledge, or a stop. The engine answers each request with a one-cycle done pulse. With that pulse it returns the received byte, or a flag saying the sent byte was not acknowledged.

Top module: `smb_blkbuf`

## Requirements
- R1: A start request (control register, address 1, bit 6 written as 1) is ignored unless buffer mode is on. Buffer mode is bit 1 of the auxiliary register (address 4), and that bit reads back as written.
- R2: Any read of the control register (address 1) sets the buffer index to 0.
- R3: A write to the data register (address 3) stores the byte at the current index and then adds 1 to the index. A read of the data register returns the byte at the current index and then adds 1 to the index.
- R4: The index wraps from 31 to 0, so the 33rd consecutive write replaces entry 0.
- R5: A block write (bit 0 of the target register at address 5 is 0) makes these requests in order: start-send of {target[7:1],0}, send of the command (address 6), send of the count (address 2), send of buffer entries 0 to count-1, then stop. Op codes are 0 start-send, 1 send, 2 receive-ack, 3 receive-nak, 4 stop.
- R6: A block read (target bit 0 is 1) makes these requests in order: start-send of {target[7:1],0}, send of the command, start-send of {target[7:1],1}, receive-ack of the count, then count receives. The last of these is receive-nak, and the stop comes after it. The count is stored at address 2, and the data goes into entries 0 upward.
- R7: A received count of 0 or above 32 is stored at address 2 and is followed directly by a stop. Completion then also sets the failed flag (status bit 4).
- R8: A block write started with a count of 0 or above 32 makes no bus request. In the next cycle the status shows done and failed (0x12).
- R9: When the stop completes, status bit 0 (busy) clears and status bit 1 (done) sets. Writing 1s to status bits 1, 2 and 4 clears those bits.
- R10: A sent byte that is not acknowledged is followed directly by a stop, and status bit 2 (device error) sets.
- R11: While busy, writes to the count, data, auxiliary, target and command registers have no effect, and neither does a start request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| bus_req | output | 1 | Byte operation requested |
| bus_op | output | 3 | Requested operation code |
| bus_tx | output | 8 | Byte to send |
| bus_done | input | 1 | Engine completed the requested operation |
| bus_nak | input | 1 | Sent byte was not acknowledged |
| bus_rx | input | 8 | Received byte, valid with bus_done |

## Verification
Register reads are combinational, so the bench samples read data one nanosecond after it raises the read strobe at a falling edge. The index effect of that read is checked on the next access. A start request changes the status in the cycle after the rising edge that accepts it, and a rejected count shows at once on the next status read. The bus sequence is recorded by a responder that answers requests at falling edges after random delays, and is then compared entry by entry with the sequence the bench expects. Busy is polled through the status register, so all results are checked only after completion, whatever the engine latency.

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       bus_req,
  output logic [2:0] bus_op,
  output logic [7:0] bus_tx,
  input  logic       bus_done,
  input  logic       bus_nak,
  input  logic [7:0] bus_rx
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [7:0] MAXB = 8'(DEPTH);
  localparam logic [2:0] A_STAT = 3'd0, A_CTRL = 3'd1, A_CNT = 3'd2, A_BLK = 3'd3,
                         A_AUX = 3'd4, A_TGT = 3'd5, A_CMD = 3'd6;
  localparam logic [2:0] OP_START = 3'd0, OP_SEND = 3'd1, OP_RECV = 3'd2,
                         OP_RLAST = 3'd3, OP_STOP = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR_W, S_CMD, S_CNT_TX, S_DATA_TX, S_ADDR_R, S_CNT_RX, S_DATA_RX, S_STOP
  } state_t;

  state_t          state;
  logic [7:0]      mem [DEPTH];
  logic [IW-1:0]   idx, k;
  logic [7:0]      cnt, tgt, cmd;
  logic            aux_en, st_done, st_dev, st_fail;

  wire busy     = (state != S_IDLE);
  wire cfg_wr   = reg_wr && !busy;
  wire blk_wr   = cfg_wr && reg_addr == A_BLK;
  wire blk_rd   = reg_rd && reg_addr == A_BLK;
  wire rewind   = reg_rd && reg_addr == A_CTRL;
  wire start    = cfg_wr && reg_addr == A_CTRL && reg_wdata[6] && aux_en;
  wire cnt_ok   = (cnt != 8'd0) && (cnt <= MAXB);
  wire rx_ok    = (bus_rx != 8'd0) && (bus_rx <= MAXB);
  wire k_last   = (8'(k) + 8'd1) == cnt;
  wire sending  = state inside {S_ADDR_W, S_CMD, S_CNT_TX, S_DATA_TX, S_ADDR_R};
  wire nak_hit  = bus_done && bus_nak && sending;
  wire [IW-1:0] idx_nx = (idx == IW'(DEPTH-1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      k       <= '0;
      cnt     <= '0;
      tgt     <= '0;
      cmd     <= '0;
      aux_en  <= 1'b0;
      st_done <= 1'b0;
      st_dev  <= 1'b0;
      st_fail <= 1'b0;
    end else begin
      if (rewind) idx <= '0;
      else if (blk_wr || blk_rd) idx <= idx_nx;

      if (cfg_wr && reg_addr == A_CNT) cnt    <= reg_wdata;
      if (cfg_wr && reg_addr == A_AUX) aux_en <= reg_wdata[1];
      if (cfg_wr && reg_addr == A_TGT) tgt    <= reg_wdata;
      if (cfg_wr && reg_addr == A_CMD) cmd    <= reg_wdata;

      if (reg_wr && reg_addr == A_STAT) begin
        if (reg_wdata[1]) st_done <= 1'b0;
        if (reg_wdata[2]) st_dev  <= 1'b0;
        if (reg_wdata[4]) st_fail <= 1'b0;
      end

      if (start) begin
        if (!tgt[0] && !cnt_ok) begin
          st_done <= 1'b1;
          st_fail <= 1'b1;
        end else begin
          state <= S_ADDR_W;
          k     <= '0;
        end
      end

      if (nak_hit) begin
        state  <= S_STOP;
        st_dev <= 1'b1;
      end else if (bus_done) begin
        case (state)
          S_ADDR_W:  state <= S_CMD;
          S_CMD:     state <= tgt[0] ? S_ADDR_R : S_CNT_TX;
          S_CNT_TX:  state <= S_DATA_TX;
          S_DATA_TX: begin
            if (k_last) state <= S_STOP;
            else k <= k + 1'b1;
          end
          S_ADDR_R:  state <= S_CNT_RX;
          S_CNT_RX: begin
            cnt <= bus_rx;
            if (rx_ok) state <= S_DATA_RX;
            else begin
              state   <= S_STOP;
              st_fail <= 1'b1;
            end
          end
          S_DATA_RX: begin
            if (k_last) state <= S_STOP;
            else k <= k + 1'b1;
          end
          S_STOP: begin
            state   <= S_IDLE;
            st_done <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (blk_wr) mem[idx] <= reg_wdata;
    else if (bus_done && state == S_DATA_RX) mem[k] <= bus_rx;
  end

  assign bus_req = busy;

  always_comb begin
    bus_op = OP_STOP;
    bus_tx = 8'h00;
    case (state)
      S_ADDR_W:  begin bus_op = OP_START; bus_tx = {tgt[7:1], 1'b0}; end
      S_CMD:     begin bus_op = OP_SEND;  bus_tx = cmd; end
      S_CNT_TX:  begin bus_op = OP_SEND;  bus_tx = cnt; end
      S_DATA_TX: begin bus_op = OP_SEND;  bus_tx = mem[k]; end
      S_ADDR_R:  begin bus_op = OP_START; bus_tx = {tgt[7:1], 1'b1}; end
      S_CNT_RX:  bus_op = OP_RECV;
      S_DATA_RX: bus_op = k_last ? OP_RLAST : OP_RECV;
      default:   bus_op = OP_STOP;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {3'b000, st_fail, 1'b0, st_dev, st_done, busy};
      A_CNT:   reg_rdata = cnt;
      A_BLK:   reg_rdata = mem[idx];
      A_AUX:   reg_rdata = {6'd0, aux_en, 1'b0};
      A_TGT:   reg_rdata = tgt;
      A_CMD:   reg_rdata = cmd;
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_NO_MODE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && !aux_en && reg_wr && reg_addr == A_CTRL) |=> !bus_req); // R1
  AST_CTRL_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CTRL) |=> (idx == '0)); // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_BLK && idx != IW'(DEPTH-1)) |=> (idx == IW'($past(idx) + 1'b1))); // R3
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_BLK && idx == IW'(DEPTH-1)) |=> (idx == '0)); // R4
  AST_K_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA_TX || state == S_DATA_RX) |-> (8'(k) < cnt && cnt <= MAXB)); // R6
  AST_BAD_RXCNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && state == S_CNT_RX && (bus_rx == 8'd0 || bus_rx > MAXB)) |=> (bus_op == OP_STOP && st_fail)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && state == S_STOP) |=> (!bus_req && st_done)); // R9
  AST_NAK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_done && bus_nak && bus_req && (bus_op == OP_START || bus_op == OP_SEND)) |=> (bus_op == OP_STOP && st_dev)); // R10
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && reg_wr && reg_addr == A_CMD) |=> $stable(cmd)); // R11
endmodule

// File: tb/smb_blkbuf_tb.sv
`timescale 1ns/1ps
module smb_blkbuf_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic bus_req, bus_done, bus_nak;
  logic [2:0] bus_op;
  logic [7:0] bus_tx, bus_rx;

  always #10 clk = ~clk;

  smb_blkbuf u_dut (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
                    .bus_req, .bus_op, .bus_tx, .bus_done, .bus_nak, .bus_rx);

  int checks = 0, errors = 0;
  int log_op [64];
  int log_tx [64];
  int log_n = 0;
  logic [7:0] rx_q [64];
  int rx_i = 0;
  int nak_at = -1;
  bit slow = 0;
  logic [7:0] bdat [33];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    bus_done = 0; bus_nak = 0; bus_rx = 0;
    forever begin
      @(negedge clk);
      if (bus_done) begin
        bus_done = 0; bus_nak = 0;
      end else if (bus_req && (!slow || ($urandom % 3) == 0)) begin
        log_op[log_n] = int'(bus_op);
        log_tx[log_n] = int'(bus_tx);
        bus_nak = (log_n == nak_at);
        if (bus_op == 3'd2 || bus_op == 3'd3) begin
          bus_rx = rx_q[rx_i];
          rx_i++;
        end
        if (log_n < 63) log_n++;
        bus_done = 1;
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    s = 8'h01;
    for (int i = 0; i < 3000 && s[0]; i++) rd(3'd0, s);
  endtask

  task automatic expect_op(string req, int i, int op, int tx, bit chk_tx);
    chk(req, log_op[i], op);
    if (chk_tx) chk(req, log_tx[i], tx);
  endtask

  task automatic block_write(logic [6:0] a, logic [7:0] c, int n);
    logic [7:0] d;
    rd(3'd1, d);
    for (int i = 0; i < n; i++) begin bdat[i] = 8'($urandom); wr(3'd3, bdat[i]); end
    wr(3'd2, 8'(n)); wr(3'd5, {a, 1'b0}); wr(3'd6, c);
    log_n = 0; rx_i = 0;
    wr(3'd1, 8'h40);
    wait_idle();
    chk("R5 op count", log_n, n + 4);
    expect_op("R5 addr", 0, 0, {a, 1'b0}, 1);
    expect_op("R5 cmd", 1, 1, c, 1);
    expect_op("R5 count", 2, 1, n, 1);
    for (int i = 0; i < n; i++) expect_op("R5 data", 3 + i, 1, bdat[i], 1);
    expect_op("R5 stop", n + 3, 4, 0, 0);
    rd(3'd0, d); chk("R9 status after write", d, 8'h02);
    wr(3'd0, 8'h16);
  endtask

  task automatic block_read(logic [6:0] a, logic [7:0] c, int n);
    logic [7:0] d;
    rx_q[0] = 8'(n);
    for (int i = 0; i < n; i++) begin bdat[i] = 8'($urandom); rx_q[i + 1] = bdat[i]; end
    wr(3'd5, {a, 1'b1}); wr(3'd6, c);
    log_n = 0; rx_i = 0;
    wr(3'd1, 8'h40);
    wait_idle();
    chk("R6 op count", log_n, n + 5);
    expect_op("R6 addr w", 0, 0, {a, 1'b0}, 1);
    expect_op("R6 cmd", 1, 1, c, 1);
    expect_op("R6 addr r", 2, 0, {a, 1'b1}, 1);
    expect_op("R6 count rx", 3, 2, 0, 0);
    for (int i = 0; i < n; i++) expect_op("R6 data rx", 4 + i, (i == n - 1) ? 3 : 2, 0, 0);
    expect_op("R6 stop", n + 4, 4, 0, 0);
    rd(3'd2, d); chk("R6 count stored", d, n);
    rd(3'd1, d);
    for (int i = 0; i < n; i++) begin rd(3'd3, d); chk("R3 R6 buffer read", d, bdat[i]); end
    rd(3'd0, d); chk("R9 status after read", d, 8'h02);
    wr(3'd0, 8'h16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd0, d); chk("reset status", d, 0);
    rd(3'd4, d); chk("reset aux", d, 0);
    rd(3'd2, d); chk("reset count", d, 0);

    // R1: start without buffer mode
    wr(3'd2, 8'd4); wr(3'd5, 8'h20); log_n = 0;
    wr(3'd1, 8'h40);
    repeat (10) @(negedge clk);
    rd(3'd0, d); chk("R1 start ignored status", d, 0);
    chk("R1 no bus ops", log_n, 0);
    wr(3'd4, 8'h02);
    rd(3'd4, d); chk("R1 aux readback", d, 8'h02);

    // R4 wrap and R2 rewind
    rd(3'd1, d);
    for (int i = 0; i < 33; i++) wr(3'd3, 8'(i + 1));
    rd(3'd1, d);
    rd(3'd3, d); chk("R4 entry0 overwritten", d, 33);
    rd(3'd3, d); chk("R3 entry1", d, 2);
    rd(3'd1, d);
    rd(3'd3, d); chk("R2 rewind to entry0", d, 33);

    // R8 bad write count
    wr(3'd5, 8'h20); wr(3'd2, 8'd0); log_n = 0;
    wr(3'd1, 8'h40);
    rd(3'd0, d); chk("R8 count 0 status", d, 8'h12);
    chk("R8 no bus ops", log_n, 0);
    wr(3'd0, 8'h16);
    rd(3'd0, d); chk("R9 w1c clears", d, 0);
    wr(3'd2, 8'd33); wr(3'd1, 8'h40);
    rd(3'd0, d); chk("R8 count 33 status", d, 8'h12);
    wr(3'd0, 8'h16);

    // directed sizes
    block_write(7'h50, 8'hA5, 1);
    block_write(7'h51, 8'h3C, 32);
    block_read(7'h52, 8'h11, 1);
    block_read(7'h53, 8'h22, 32);

    // R7 bad received count
    foreach (rx_q[i]) rx_q[i] = 8'h00;
    for (int t = 0; t < 2; t++) begin
      rx_q[0] = (t == 0) ? 8'd0 : 8'd40;
      wr(3'd5, 8'h61); log_n = 0; rx_i = 0;
      wr(3'd1, 8'h40);
      wait_idle();
      chk("R7 op count", log_n, 5);
      expect_op("R7 stop after count", 4, 4, 0, 0);
      rd(3'd0, d); chk("R7 failed status", d, 8'h12);
      rd(3'd2, d); chk("R7 count stored", d, rx_q[0]);
      wr(3'd0, 8'h16);
    end

    // R10 nak on command byte
    wr(3'd2, 8'd3); wr(3'd5, 8'h40); wr(3'd6, 8'h77);
    nak_at = 1; log_n = 0;
    wr(3'd1, 8'h40);
    wait_idle();
    nak_at = -1;
    chk("R10 op count", log_n, 3);
    expect_op("R10 stop", 2, 4, 0, 0);
    rd(3'd0, d); chk("R10 dev error status", d, 8'h06);
    wr(3'd0, 8'h16);

    // R11 writes while busy
    slow = 1;
    wr(3'd2, 8'd8); wr(3'd5, 8'h40); wr(3'd6, 8'h5A); log_n = 0;
    wr(3'd1, 8'h40);
    wr(3'd6, 8'h99); wr(3'd4, 8'h00); wr(3'd2, 8'd2);
    wait_idle();
    rd(3'd6, d); chk("R11 cmd held", d, 8'h5A);
    rd(3'd4, d); chk("R11 aux held", d, 8'h02);
    rd(3'd2, d); chk("R11 count held", d, 8);
    chk("R11 full transfer", log_n, 12);
    wr(3'd0, 8'h16);

    // random mix
    for (int it = 0; it < 12; it++) begin
      slow = $urandom % 2;
      if ($urandom % 2) block_write(7'($urandom), 8'($urandom), 1 + int'($urandom % 32));
      else block_read(7'($urandom), 8'($urandom), 1 + int'($urandom % 32));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule